// File: doc/BRIEF.md
# Video Memory Write Queue

This block sits between the host data port (and the DMA load engine) and the three video-side memories: pattern/name RAM (VRAM), palette RAM (CRAM) and scroll RAM (VSRAM). Each accepted write lands in a four-deep queue, together with its destination code, a 17-bit address, 16-bit data, two byte-valid flags and an aging counter. An entry must age for a fixed number of access slots before it can drain. The memory arbiter offers the queue one access slot at a time. When the queue uses the slot it raises `serviced`, so that the arbiter can hand unused slots to the read prefetch path.

A VRAM word is written as two byte accesses to the same address, low byte first. The entry retires only after the high byte has been written. A CRAM write stores a packed 9-bit colour and latches that colour as a "bus active" value, which the display uses to draw a dot artifact. Whenever the head retires while a DMA fill is waiting, the queue passes the fill word on and releases the fill.

Top module: `vid_wr_fifo`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0) and nothing is serviced. `full` is 1 exactly when all four entries are occupied. An empty queue never issues a write.
- R2: A write presented while `full` is 1 is dropped. Only the four earlier writes ever reach memory.
- R3: A new entry starts with an age count of 2. The count falls by one on each cycle with `slot_tick`=1 and is not touched otherwise. The head drains only when its count is 0. With `slot_tick` and `slot_grant` held at 1, a write presented in cycle c is serviced in cycle c+3.
- R4: The head does not drain while `dma_active` and `dma_preload_nz` are both 1.
- R5: A VRAM entry (target code 1) needs two serviced slots at the same `mem_addr`. The first has `vram_hi`=0 and `vram_byte`=data[7:0]. The second has `vram_hi`=1 and `vram_byte`=data[15:8]. The entry stays queued between the two accesses.
- R6: A CRAM entry (target code 3) drains in one slot, with `cram_color` = {data[11:9], data[7:5], data[3:1]}. A VSRAM entry (target code 5) drains in one slot, with `mem_data` = data.
- R7: Entries drain in the order in which they were accepted.
- R8: `fill_load` pulses only in a cycle where the head retires while `fill_pending`=1. `fill_data` is the head's data if the head targets VRAM, and the data of the entry behind it otherwise.
- R9: After a CRAM write, `dot_active` is 1 and `dot_color` holds the written colour. It stays so until a cycle with `dot_clr`=1 and no new CRAM write.
- R10: `serviced` is 1 only in a slot where exactly one memory write strobe is issued. An entry with any other target code retires without a strobe or `serviced`.
- R11: Nothing is serviced in a cycle with `slot_grant`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request from host port or DMA load |
| wr_tgt | input | 4 | Target code (1 VRAM, 3 CRAM, 5 VSRAM) |
| wr_addr | input | 17 | Write address |
| wr_data | input | 16 | Write data |
| slot_grant | input | 1 | Memory access slot offered this cycle |
| slot_tick | input | 1 | Non-refresh slot: age the queued entries |
| dma_active | input | 1 | DMA transfer in progress |
| dma_preload_nz | input | 1 | DMA preload count is nonzero |
| fill_pending | input | 1 | DMA fill waiting for its data word |
| dot_clr | input | 1 | Clear the CRAM bus-active flag |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entry occupied |
| serviced | output | 1 | A memory write is issued in this slot |
| vram_we | output | 1 | VRAM byte write strobe |
| vram_hi | output | 1 | VRAM byte select: 1 high byte, 0 low byte |
| vram_byte | output | 8 | VRAM byte write data |
| cram_we | output | 1 | CRAM write strobe |
| cram_color | output | 9 | Packed CRAM colour |
| vsram_we | output | 1 | VSRAM write strobe |
| mem_addr | output | 17 | Address of the current write |
| mem_data | output | 16 | Word data of the current write |
| fill_load | output | 1 | Fill word handed over and fill wait released |
| fill_data | output | 16 | Fill word |
| dot_active | output | 1 | CRAM bus-active flag |
| dot_color | output | 9 | Colour held on the CRAM bus |

## Verification
The bench counts cycles from a write to its first service. A queue that skipped the aging, started it at the wrong value, or aged on non-tick cycles would service a cycle early or late. It fills the queue while the slot is withheld and then drains it. This catches a fifth write that sneaks in, a broken rotation that reorders or duplicates entries, and a full flag raised one entry too soon. It checks the two VRAM byte accesses for order, address and the entry's presence between them. It checks the fill hand-off, where taking data from the wrong entry shows up as the wrong word. A table of CRAM words with scattered bit patterns exposes any mistake in the colour bit packing.

// File: rtl/vwf_pkg.sv
package vwf_pkg;

    localparam int DEPTH    = 4;
    localparam int ADDR_W   = 17;
    localparam int DATA_W   = 16;
    localparam int TGT_W    = 4;
    localparam int COLOR_W  = 9;
    localparam int LAT_INIT = 2;
    localparam int LAT_W    = $clog2(LAT_INIT + 1);

    localparam logic [TGT_W-1:0] TGT_VRAM  = 4'd1;
    localparam logic [TGT_W-1:0] TGT_CRAM  = 4'd3;
    localparam logic [TGT_W-1:0] TGT_VSRAM = 4'd5;

    typedef struct packed {
        logic [TGT_W-1:0]  tgt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              hi_v;
        logic              lo_v;
        logic [LAT_W-1:0]  lat;
    } entry_t;

    // Three 3-bit colour components taken from the odd-aligned fields of the word
    function automatic logic [COLOR_W-1:0] pack_color(logic [DATA_W-1:0] d);
        return {d[11:9], d[7:5], d[3:1]};
    endfunction

    function automatic entry_t age_entry(entry_t e, logic dec, logic clr_lo);
        entry_t r;
        r = e;
        if (dec && e.lat != '0) r.lat = e.lat - 1'b1;
        if (clr_lo) r.lo_v = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/vwf_store.sv
module vwf_store
    import vwf_pkg::*;
#(
    parameter int DEPTH_P  = DEPTH,
    parameter int LAT_INIT_P = LAT_INIT,
    localparam int CW = $clog2(DEPTH_P + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              push,
    input  logic [TGT_W-1:0]  push_tgt,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              clr_lower,
    output entry_t            q [DEPTH_P],
    output logic [CW-1:0]     count
);

    entry_t        aged [DEPTH_P];
    entry_t        nxt  [DEPTH_P];
    logic [CW-1:0] cnt_after;
    logic [CW-1:0] cnt_n;

    // Per-slot aging: only occupied entries count down
    for (genvar g = 0; g < DEPTH_P; g++) begin : g_age
        assign aged[g] = age_entry(q[g], tick && (CW'(g) < count), (g == 0) && clr_lower);
    end

    always_comb begin
        cnt_after = count;
        for (int i = 0; i < DEPTH_P; i++) nxt[i] = aged[i];
        if (pop) begin
            for (int i = 0; i < DEPTH_P - 1; i++) nxt[i] = aged[i + 1];
            nxt[DEPTH_P - 1] = '0;
            cnt_after = count - CW'(1);
        end
        if (push) begin
            for (int i = 0; i < DEPTH_P; i++) begin
                if (CW'(i) == cnt_after) begin
                    nxt[i].tgt  = push_tgt;
                    nxt[i].addr = push_addr;
                    nxt[i].data = push_data;
                    nxt[i].hi_v = 1'b1;
                    nxt[i].lo_v = 1'b1;
                    nxt[i].lat  = LAT_W'(LAT_INIT_P);
                end
            end
        end
        cnt_n = cnt_after + CW'(push);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH_P; i++) q[i] <= '0;
        end else begin
            count <= cnt_n;
            for (int i = 0; i < DEPTH_P; i++) q[i] <= nxt[i];
        end
    end

endmodule

// File: rtl/vwf_drain.sv
module vwf_drain
    import vwf_pkg::*;
(
    input  entry_t             head,
    input  logic [DATA_W-1:0]  next_data,
    input  logic               head_valid,
    input  logic               grant,
    input  logic               dma_active,
    input  logic               dma_preload_nz,
    input  logic               fill_pending,
    output logic               serviced,
    output logic               vram_we,
    output logic               vram_hi,
    output logic               cram_we,
    output logic               vsram_we,
    output logic               clr_lower,
    output logic               pop,
    output logic               fill_load,
    output logic [DATA_W-1:0]  fill_data
);

    logic eligible;

    assign eligible = head_valid && grant && (head.lat == '0) && !(dma_active && dma_preload_nz);

    always_comb begin
        vram_we   = 1'b0;
        vram_hi   = 1'b0;
        cram_we   = 1'b0;
        vsram_we  = 1'b0;
        clr_lower = 1'b0;
        pop       = 1'b0;
        if (eligible) begin
            case (head.tgt)
                TGT_VRAM: begin
                    vram_we = 1'b1;
                    if (head.lo_v) begin
                        clr_lower = 1'b1;
                    end else begin
                        vram_hi = 1'b1;
                        pop     = 1'b1;
                    end
                end
                TGT_CRAM: begin
                    cram_we = 1'b1;
                    pop     = 1'b1;
                end
                TGT_VSRAM: begin
                    vsram_we = 1'b1;
                    pop      = 1'b1;
                end
                default: pop = 1'b1;
            endcase
        end
        serviced  = vram_we || cram_we || vsram_we;
        fill_load = pop && fill_pending;
        fill_data = (head.tgt == TGT_VRAM) ? head.data : next_data;
    end

endmodule

// File: rtl/vwf_dot.sv
module vwf_dot
    import vwf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               set,
    input  logic [COLOR_W-1:0] color,
    input  logic               clr,
    output logic               active,
    output logic [COLOR_W-1:0] held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            held   <= '0;
        end else if (set) begin
            active <= 1'b1;
            held   <= color;
        end else if (clr) begin
            active <= 1'b0;
        end
    end

endmodule

// File: rtl/vid_wr_fifo.sv
module vid_wr_fifo
    import vwf_pkg::*;
#(
    parameter int DEPTH_P    = DEPTH,
    parameter int LAT_INIT_P = LAT_INIT,
    localparam int CW = $clog2(DEPTH_P + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    input  logic [TGT_W-1:0]   wr_tgt,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               slot_grant,
    input  logic               slot_tick,
    input  logic               dma_active,
    input  logic               dma_preload_nz,
    input  logic               fill_pending,
    input  logic               dot_clr,
    output logic               full,
    output logic               empty,
    output logic               serviced,
    output logic               vram_we,
    output logic               vram_hi,
    output logic [7:0]         vram_byte,
    output logic               cram_we,
    output logic [COLOR_W-1:0] cram_color,
    output logic               vsram_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_data,
    output logic               fill_load,
    output logic [DATA_W-1:0]  fill_data,
    output logic               dot_active,
    output logic [COLOR_W-1:0] dot_color
);

    entry_t        q [DEPTH_P];
    logic [CW-1:0] count;
    logic          push, pop, clr_lower;

    assign full  = (count == CW'(DEPTH_P));
    assign empty = (count == '0);
    assign push  = wr_valid && !full;

    vwf_store #(.DEPTH_P(DEPTH_P), .LAT_INIT_P(LAT_INIT_P)) store_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (slot_tick),
        .push      (push),
        .push_tgt  (wr_tgt),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop       (pop),
        .clr_lower (clr_lower),
        .q         (q),
        .count     (count)
    );

    vwf_drain drain_i (
        .head           (q[0]),
        .next_data      (q[1].data),
        .head_valid     (!empty),
        .grant          (slot_grant),
        .dma_active     (dma_active),
        .dma_preload_nz (dma_preload_nz),
        .fill_pending   (fill_pending),
        .serviced       (serviced),
        .vram_we        (vram_we),
        .vram_hi        (vram_hi),
        .cram_we        (cram_we),
        .vsram_we       (vsram_we),
        .clr_lower      (clr_lower),
        .pop            (pop),
        .fill_load      (fill_load),
        .fill_data      (fill_data)
    );

    assign mem_addr   = q[0].addr;
    assign mem_data   = q[0].data;
    assign vram_byte  = vram_hi ? q[0].data[15:8] : q[0].data[7:0];
    assign cram_color = pack_color(q[0].data);

    vwf_dot dot_i (
        .clk    (clk),
        .rst    (rst),
        .set    (cram_we),
        .color  (cram_color),
        .clr    (dot_clr),
        .active (dot_active),
        .held   (dot_color)
    );

endmodule

// File: rtl/vwf_checker.sv
module vwf_checker
    import vwf_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_valid,
    input logic               slot_grant,
    input logic               dma_active,
    input logic               dma_preload_nz,
    input logic               fill_pending,
    input logic               empty,
    input logic               serviced,
    input logic               vram_we,
    input logic               vram_hi,
    input logic               cram_we,
    input logic [COLOR_W-1:0] cram_color,
    input logic               fill_load,
    input logic               dot_active,
    input logic [COLOR_W-1:0] dot_color
);

    assert_empty_idle_R1: assert property (@(posedge clk) disable iff (rst)
        empty |-> !serviced);

    assert_fresh_entry_waits_R3: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_valid) |=> !serviced);

    assert_preload_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (dma_active && dma_preload_nz) |-> !serviced);

    assert_low_byte_keeps_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (vram_we && !vram_hi) |=> !empty);

    assert_fill_needs_pending_R8: assert property (@(posedge clk) disable iff (rst)
        fill_load |-> fill_pending);

    assert_dot_latch_R9: assert property (@(posedge clk) disable iff (rst)
        cram_we |=> (dot_active && dot_color == $past(cram_color)));

    assert_no_grant_no_write_R11: assert property (@(posedge clk) disable iff (rst)
        !slot_grant |-> !serviced);

endmodule

bind vid_wr_fifo vwf_checker chk_i (.*);

// File: tb/vid_wr_fifo_tb.sv
`timescale 1ns/1ps
module vid_wr_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid;
    logic [3:0]  wr_tgt;
    logic [16:0] wr_addr;
    logic [15:0] wr_data;
    logic        slot_grant, slot_tick, dma_active, dma_preload_nz, fill_pending, dot_clr;
    logic        full, empty, serviced, vram_we, vram_hi, cram_we, vsram_we, fill_load, dot_active;
    logic [7:0]  vram_byte;
    logic [8:0]  cram_color, dot_color;
    logic [16:0] mem_addr;
    logic [15:0] mem_data, fill_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    vid_wr_fifo dut_i (.*);

    localparam int NV = 6;
    localparam logic [15:0] VEC_D [NV] = '{16'h0EEE, 16'h0002, 16'h0020, 16'h0200, 16'hF111, 16'h0A4C};
    localparam logic [8:0]  VEC_C [NV] = '{9'h1FF,   9'h001,   9'h008,   9'h040,   9'h000,   9'h156};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] t, input logic [16:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_tgt = t; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_srv(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            #1;
            if (serviced) begin
                ok = 1'b1;
                return;
            end
        end
    endtask

    initial begin
        #(100_000 * 5);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit ok;
        rst = 1'b1; wr_valid = 1'b0; wr_tgt = '0; wr_addr = '0; wr_data = '0;
        slot_grant = 1'b1; slot_tick = 1'b1; dma_active = 1'b0; dma_preload_nz = 1'b0;
        fill_pending = 1'b0; dot_clr = 1'b0;
        idle(3);
        #1;
        chk("R1 reset empty", 32'(empty), 1);
        chk("R1 reset full", 32'(full), 0);
        chk("R1 reset serviced", 32'(serviced), 0);
        chk("R9 reset dot", 32'(dot_active), 0);
        @(negedge clk);
        rst = 1'b0;

        // Vector table: CRAM colour packing (R6)
        for (int v = 0; v < NV; v++) begin
            push(4'd3, 17'(v), VEC_D[v]);
            wait_srv(ok);
            chk("R6 cram serviced", 32'(ok), 1);
            chk("R6 cram strobe", 32'(cram_we), 1);
            chk("R6 cram color", 32'(cram_color), 32'(VEC_C[v]));
        end
        idle(2);

        // R3: exact aging with tick and grant held high
        @(negedge clk);
        wr_valid = 1'b1; wr_tgt = 4'd5; wr_addr = 17'h10; wr_data = 16'hA5A5;
        @(negedge clk);
        wr_valid = 1'b0;
        #1 chk("R3 c+1 not serviced", 32'(serviced), 0);
        @(negedge clk);
        #1 chk("R3 c+2 not serviced", 32'(serviced), 0);
        @(negedge clk);
        #1 chk("R3 c+3 serviced", 32'(serviced), 1);
        idle(2);

        // R3: no aging without slot_tick
        slot_tick = 1'b0;
        push(4'd5, 17'h11, 16'h0101);
        idle(6);
        #1 chk("R3 frozen age blocks drain", 32'(serviced), 0);
        @(negedge clk);
        slot_tick = 1'b1;
        #1 chk("R3 tick1 not yet", 32'(serviced), 0);
        @(negedge clk);
        #1 chk("R3 tick2 not yet", 32'(serviced), 0);
        @(negedge clk);
        #1 chk("R3 drains after two ticks", 32'(serviced), 1);
        idle(2);

        // R11 and R4: grant withheld, then DMA preload blocks
        slot_grant = 1'b0;
        push(4'd5, 17'h12, 16'h0202);
        idle(5);
        #1 chk("R11 no grant no service", 32'(serviced), 0);
        @(negedge clk);
        slot_grant = 1'b1; dma_active = 1'b1; dma_preload_nz = 1'b1;
        #1 chk("R4 preload blocks head", 32'(serviced), 0);
        @(negedge clk);
        #1 chk("R4 preload still blocks", 32'(serviced), 0);
        @(negedge clk);
        dma_preload_nz = 1'b0;
        #1 chk("R4 drains when preload clears", 32'(serviced), 1);
        @(negedge clk);
        dma_active = 1'b0;
        idle(2);

        // R5: VRAM two byte accesses, low byte first
        slot_grant = 1'b0;
        push(4'd1, 17'h12345, 16'hBEEF);
        idle(4);
        @(negedge clk);
        slot_grant = 1'b1;
        #1;
        chk("R5 low access strobe", 32'(vram_we), 1);
        chk("R5 low select", 32'(vram_hi), 0);
        chk("R5 low byte", 32'(vram_byte), 32'hEF);
        chk("R5 low addr", 32'(mem_addr), 32'h12345);
        @(negedge clk);
        #1;
        chk("R5 entry kept between accesses", 32'(empty), 0);
        chk("R5 high access strobe", 32'(vram_we), 1);
        chk("R5 high select", 32'(vram_hi), 1);
        chk("R5 high byte", 32'(vram_byte), 32'hBE);
        chk("R5 high addr", 32'(mem_addr), 32'h12345);
        @(negedge clk);
        #1 chk("R5 retired after high byte", 32'(empty), 1);
        idle(2);

        // R1, R2, R7: fill to capacity, overflow dropped, order kept
        slot_grant = 1'b0;
        for (int k = 1; k <= 4; k++) push(4'd5, 17'(k), 16'(k));
        #1 chk("R1 full after four", 32'(full), 1);
        push(4'd5, 17'h5, 16'h0005);
        idle(4);
        @(negedge clk);
        slot_grant = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            if (k > 1) wait_srv(ok); else #1;
            chk("R7 vsram strobe", 32'(vsram_we), 1);
            chk("R7 drain order", 32'(mem_data), 32'(k));
        end
        @(negedge clk);
        #1 chk("R2 overflow write dropped", 32'(empty), 1);
        idle(2);

        // R8: fill hand-off; R9: dot flag
        slot_grant = 1'b0;
        push(4'd1, 17'h20, 16'h1111);
        push(4'd3, 17'h21, 16'h2222);
        push(4'd5, 17'h22, 16'h3333);
        idle(4);
        @(negedge clk);
        slot_grant = 1'b1; fill_pending = 1'b1;
        #1 chk("R8 no hand-off on low byte", 32'(fill_load), 0);
        @(negedge clk);
        #1;
        chk("R8 hand-off on vram retire", 32'(fill_load), 1);
        chk("R8 vram head supplies data", 32'(fill_data), 32'h1111);
        @(negedge clk);
        #1;
        chk("R8 hand-off on cram retire", 32'(fill_load), 1);
        chk("R8 next entry supplies data", 32'(fill_data), 32'h3333);
        @(negedge clk);
        fill_pending = 1'b0;
        #1;
        chk("R9 dot raised", 32'(dot_active), 1);
        chk("R9 dot color", 32'(dot_color), 32'h049);
        @(negedge clk);
        #1 chk("R9 dot held", 32'(dot_active), 1);
        dot_clr = 1'b1;
        @(negedge clk);
        dot_clr = 1'b0;
        #1 chk("R9 dot cleared", 32'(dot_active), 0);
        idle(2);

        // R10: unknown target retires silently
        push(4'd7, 17'h30, 16'hDEAD);
        push(4'd5, 17'h31, 16'h0055);
        wait_srv(ok);
        chk("R10 first service is next entry", 32'(mem_data), 32'h0055);
        chk("R10 single strobe", 32'(vsram_we && !vram_we && !cram_we), 1);
        @(negedge clk);
        #1 chk("R10 queue empty", 32'(empty), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule